// File: doc/BRIEF.md
# Transponder Readout Sequencer

The block drives the load modulator of a passive low-frequency transponder. It runs on the clock recovered from the reader's field. After reset it loops over one selected data source with no gap between passes. The source is one of three: eight 16-bit user words, a 64-bit identification code, or a 128-bit frame that carries the configuration word. Each bit is line-coded as Manchester or bi-phase and lasts 64 or 32 field periods. A low level on the output means the load is connected and a high level means it is released.

After a successful memory write, the command logic pulses a request. The block then replaces the data stream with an acknowledge burst lasting two bit periods, whose load toggles every quarter bit. Readout then starts again from the first bit. A one-cycle pulse marks the end of every complete pass, so that a command detector can time its blanking window. The user memory itself sits outside the block: the sequencer presents a word address and takes the read data back in the same cycle.

Top module: `rfid_readout_seq`

## Requirements
- R1: A bit lasts 64 clock cycles when `fastRate` is 0 and 32 clock cycles when it is 1.
- R2: With `srcSel` = 0 (user memory; value 3 behaves the same), bits go out starting at word 0 bit 0 and rising through bit 15. They then continue through words 1 to 7 and wrap to word 0 bit 0 with no idle cycle. `wordAddr` carries the word being sent.
- R3: With `srcSel` = 1, the 64 bits of `romData` go out from bit 0 upward and repeat without a gap.
- R4: With `biPhase` = 0 (Manchester), `modLevel` equals the data bit in the first half of the bit and its inverse in the second half. A high level means load off.
- R5: With `biPhase` = 1, `modLevel` inverts at the start of every bit, and inverts again at mid-bit only when the bit is 0. The first bit after a restart begins low.
- R6: With `srcSel` = 2, a 128-bit frame is sent whose positions 0 to 15 are `cfgWord` bits 0 to 15 and whose other 112 positions are 0.
- R7: While `rstN` is low, `modLevel` is 1 and `cycleDone` is 0. Bit 0 starts on the first rising clock edge after release.
- R8: `cycleDone` is high for exactly the last clock cycle of the last bit of each pass (bit 127, or bit 63 for the code source).
- R9: A high `ackReq` sampled during readout starts a burst of two bit periods. Its level is 0 for the first quarter bit and alternates every quarter bit after that. `ackReq` has no effect during a burst, and `cycleDone` stays 0. On the edge that ends the burst, readout restarts at bit 0.
- R10: A change of `srcSel` during readout restarts at bit 0 of the new source on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered field clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 2 | Source: 0 user memory, 1 identification code, 2 configuration frame, 3 user memory |
| biPhase | input | 1 | 1 selects bi-phase, 0 selects Manchester |
| fastRate | input | 1 | 1 selects 32 cycles per bit, 0 selects 64 |
| ackReq | input | 1 | Starts the acknowledge burst |
| memRdData | input | 16 | User memory word at `wordAddr` |
| romData | input | 64 | Identification code, bit 0 sent first |
| cfgWord | input | 16 | Configuration word |
| wordAddr | output | 3 | User memory word address |
| modLevel | output | 1 | Modulator control, 0 = load on |
| cycleDone | output | 1 | End-of-pass pulse |

## Verification
On every cycle, the assertions check the parts of the timing that can be stated locally. The Manchester mid-bit inversion and the bi-phase bit-start inversion are checked at the output. The bit index must stay inside the current frame. Readout must land on bit 0 after a pass end, and after a burst ends. The output must stay released during reset. The bench's scenarios compare the whole encoded stream against an independent model, which is the only way to show the following: the bit ordering of each source, the zero fill of the configuration frame, the exact placement of the pass pulse, the square-wave shape of the burst, that a request during a burst is ignored, and the restart after a source change.

// File: rtl/rfid_seq_pkg.sv
package rfid_seq_pkg;

  localparam logic [1:0] SRC_USER = 2'd0;
  localparam logic [1:0] SRC_ROM  = 2'd1;
  localparam logic [1:0] SRC_CFG  = 2'd2;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic run;         // readout or burst active (out of reset)
    logic ack;         // acknowledge burst in progress
    logic ackLevel;    // burst square-wave level
    logic advance;     // normal stepping this cycle
    logic midEdge;     // last cycle of the first half-bit
    logic endEdge;     // last cycle of the bit
    logic secondHalf;  // current cycle lies in the second half-bit
    logic restart;     // next edge starts again at bit 0
  } seqStrobe_t;

endpackage

// File: rtl/rfid_seq_ctrl.sv
module rfid_seq_ctrl
  import rfid_seq_pkg::*;
#(
  parameter int SLOW_PERIOD = 64,
  parameter int FAST_PERIOD = 32,
  parameter int WORDS       = 8,
  parameter int WORD_BITS   = 16,
  parameter int ROM_BITS    = 64,
  localparam int FRAME_BITS = WORDS * WORD_BITS,
  localparam int IDX_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastRate,
  input  logic [1:0]       srcSel,
  input  logic             ackReq,
  output seqStrobe_t       strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic [1:0]       curSrc,
  output logic             cycleDone
);

  localparam int PH_W   = $clog2(SLOW_PERIOD);
  localparam int ACK_W  = $clog2(2 * SLOW_PERIOD);
  localparam int Q_SLOW = $clog2(SLOW_PERIOD / 4);
  localparam int Q_FAST = $clog2(FAST_PERIOD / 4);

  logic             runR;
  logic             ackR;
  logic [PH_W-1:0]  phaseCnt;
  logic [ACK_W-1:0] ackCnt;

  logic [PH_W-1:0]  lastPh;
  logic [PH_W-1:0]  halfPh;
  logic [ACK_W-1:0] ackLast;
  logic [IDX_W-1:0] lastIdx;
  logic             srcChange;
  logic             ackDone;
  logic             advance;

  always_comb begin
    lastPh    = fastRate ? PH_W'(FAST_PERIOD - 1) : PH_W'(SLOW_PERIOD - 1);
    halfPh    = fastRate ? PH_W'(FAST_PERIOD / 2 - 1) : PH_W'(SLOW_PERIOD / 2 - 1);
    ackLast   = fastRate ? ACK_W'(2 * FAST_PERIOD - 1) : ACK_W'(2 * SLOW_PERIOD - 1);
    lastIdx   = (curSrc == SRC_ROM) ? IDX_W'(ROM_BITS - 1) : IDX_W'(FRAME_BITS - 1);
    ackDone   = ackR && (ackCnt == ackLast);
    srcChange = runR && !ackR && !ackReq && (srcSel != curSrc);
    advance   = runR && !ackR && !ackReq && !srcChange;
    cycleDone = advance && (phaseCnt == lastPh) && (bitIdx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runR     <= 1'b0;
      ackR     <= 1'b0;
      ackCnt   <= '0;
      phaseCnt <= '0;
      bitIdx   <= '0;
      curSrc   <= SRC_USER;
    end else if (!runR) begin
      runR     <= 1'b1;
      curSrc   <= srcSel;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (ackR) begin
      if (ackDone) begin
        ackR     <= 1'b0;
        ackCnt   <= '0;
        phaseCnt <= '0;
        bitIdx   <= '0;
        curSrc   <= srcSel;
      end else begin
        ackCnt <= ackCnt + 1'b1;
      end
    end else if (ackReq) begin
      ackR   <= 1'b1;
      ackCnt <= '0;
    end else if (srcChange) begin
      curSrc   <= srcSel;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (phaseCnt == lastPh) begin
      phaseCnt <= '0;
      bitIdx   <= (bitIdx == lastIdx) ? '0 : bitIdx + 1'b1;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    strb.run        = runR;
    strb.ack        = ackR;
    strb.ackLevel   = fastRate ? ackCnt[Q_FAST] : ackCnt[Q_SLOW];
    strb.advance    = advance;
    strb.midEdge    = (phaseCnt == halfPh);
    strb.endEdge    = (phaseCnt == lastPh);
    strb.secondHalf = (phaseCnt > halfPh);
    strb.restart    = !runR || ackDone || srcChange;
  end

  // R2 / R3: index stays inside the frame of the current source
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    runR |-> (bitIdx <= lastIdx));

  // R1: phase never passes the bit length of the selected rate
  a_r1_phase_bound: assert property (@(posedge clk) disable iff (!rstN)
    runR |-> (phaseCnt <= lastPh));

  // R8: a pass end is followed by bit 0, field period 0
  a_r8_wrap_after_done: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> (bitIdx == '0 && phaseCnt == '0));

  // R9: a burst either continues or hands over to bit 0
  a_r9_ack_exit: assert property (@(posedge clk) disable iff (!rstN)
    ackR |=> (ackR || (bitIdx == '0 && phaseCnt == '0)));

endmodule

// File: rtl/rfid_seq_dpath.sv
module rfid_seq_dpath
  import rfid_seq_pkg::*;
#(
  parameter int WORDS     = 8,
  parameter int WORD_BITS = 16,
  parameter int ROM_BITS  = 64,
  localparam int FRAME_BITS = WORDS * WORD_BITS,
  localparam int IDX_W      = $clog2(FRAME_BITS),
  localparam int BIT_W      = $clog2(WORD_BITS),
  localparam int ADDR_W     = $clog2(WORDS),
  localparam int ROM_W      = $clog2(ROM_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 biPhase,
  input  seqStrobe_t           strb,
  input  logic [IDX_W-1:0]     bitIdx,
  input  logic [1:0]           curSrc,
  input  logic [WORD_BITS-1:0] memRdData,
  input  logic [ROM_BITS-1:0]  romData,
  input  logic [WORD_BITS-1:0] cfgWord,
  output logic [ADDR_W-1:0]    wordAddr,
  output logic                 modLevel
);

  logic [BIT_W-1:0] bitSel;
  logic             dataBit;
  logic             bpLevel;
  logic             encLevel;

  always_comb begin
    wordAddr = bitIdx[IDX_W-1:BIT_W];
    bitSel   = bitIdx[BIT_W-1:0];
    case (curSrc)
      SRC_ROM: dataBit = romData[bitIdx[ROM_W-1:0]];
      SRC_CFG: dataBit = (bitIdx < IDX_W'(WORD_BITS)) ? cfgWord[bitSel] : 1'b0;
      default: dataBit = memRdData[bitSel];
    endcase
  end

  // bi-phase level: flips at each bit end, and at mid-bit for a zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpLevel <= 1'b0;
    end else if (strb.restart) begin
      bpLevel <= 1'b0;
    end else if (strb.advance) begin
      if (strb.endEdge || (strb.midEdge && !dataBit)) begin
        bpLevel <= ~bpLevel;
      end
    end
  end

  always_comb begin
    encLevel = biPhase ? bpLevel : (dataBit ^ strb.secondHalf);
    if (!strb.run)     modLevel = 1'b1;
    else if (strb.ack) modLevel = strb.ackLevel;
    else               modLevel = encLevel;
  end

  // R4: Manchester output inverts across the mid-bit edge
  a_r4_manchester_mid: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.midEdge && !biPhase) |=> (modLevel != $past(modLevel)));

  // R5: bi-phase output inverts across every bit boundary
  a_r5_biphase_edge: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.endEdge && biPhase) |=> (modLevel != $past(modLevel)));

endmodule

// File: rtl/rfid_readout_seq.sv
module rfid_readout_seq
  import rfid_seq_pkg::*;
#(
  parameter int SLOW_PERIOD = 64,
  parameter int FAST_PERIOD = 32,
  parameter int WORDS       = 8,
  parameter int WORD_BITS   = 16,
  parameter int ROM_BITS    = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               srcSel,
  input  logic                     biPhase,
  input  logic                     fastRate,
  input  logic                     ackReq,
  input  logic [WORD_BITS-1:0]     memRdData,
  input  logic [ROM_BITS-1:0]      romData,
  input  logic [WORD_BITS-1:0]     cfgWord,
  output logic [$clog2(WORDS)-1:0] wordAddr,
  output logic                     modLevel,
  output logic                     cycleDone
);

  localparam int IDX_W = $clog2(WORDS * WORD_BITS);

  seqStrobe_t       strb;
  logic [IDX_W-1:0] bitIdx;
  logic [1:0]       curSrc;

  rfid_seq_ctrl #(
    .SLOW_PERIOD(SLOW_PERIOD), .FAST_PERIOD(FAST_PERIOD),
    .WORDS(WORDS), .WORD_BITS(WORD_BITS), .ROM_BITS(ROM_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .fastRate(fastRate), .srcSel(srcSel),
    .ackReq(ackReq), .strb(strb), .bitIdx(bitIdx), .curSrc(curSrc),
    .cycleDone(cycleDone)
  );

  rfid_seq_dpath #(
    .WORDS(WORDS), .WORD_BITS(WORD_BITS), .ROM_BITS(ROM_BITS)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .biPhase(biPhase), .strb(strb),
    .bitIdx(bitIdx), .curSrc(curSrc), .memRdData(memRdData),
    .romData(romData), .cfgWord(cfgWord), .wordAddr(wordAddr),
    .modLevel(modLevel)
  );

  // R7: load released and no pass pulse while reset is held
  a_r7_reset_released: assert property (@(negedge clk)
    !rstN |-> (modLevel && !cycleDone));

endmodule

// File: tb/rfid_readout_seq_tb_top.sv
module rfid_readout_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  srcSel = 2'd0;
  logic        biPhase = 1'b0;
  logic        fastRate = 1'b0;
  logic        ackReq = 1'b0;
  logic [15:0] memRdData;
  logic [63:0] romData = 64'hFF80_1234_5678_9ABC;
  logic [15:0] cfgWord = 16'h4D21;
  logic [2:0]  wordAddr;
  logic        modLevel;
  logic        cycleDone;

  logic [15:0] mem [8];
  int          totalCnt = 0;
  int          failCnt = 0;

  always #10 clk = ~clk;

  assign memRdData = mem[wordAddr];

  rfid_readout_seq dut_i (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .biPhase(biPhase),
    .fastRate(fastRate), .ackReq(ackReq), .memRdData(memRdData),
    .romData(romData), .cfgWord(cfgWord), .wordAddr(wordAddr),
    .modLevel(modLevel), .cycleDone(cycleDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit expBit(input int src, input int idx);
    if (src == 1) return romData[idx % 64];
    if (src == 2) return (idx < 16) ? cfgWord[idx] : 1'b0;
    return mem[idx / 16][idx % 16];
  endfunction

  // reset with the given options; checks R7 while held
  task automatic startFresh(input int src, input bit bp, input bit fast);
    @(negedge clk);
    rstN = 1'b0;
    srcSel = src[1:0];
    biPhase = bp;
    fastRate = fast;
    ackReq = 1'b0;
    repeat (2) @(negedge clk);
    check(modLevel == 1'b1 && cycleDone == 1'b0, "R7 reset state",
          {modLevel, cycleDone}, 2);
    rstN = 1'b1;
  endtask

  // waits for the edge that starts bit 0, then compares n cycles
  task automatic runStream(input int src, input bit bp, input bit fast,
                           input int n, input string req);
    int  per;
    int  frame;
    int  bad;
    int  dones;
    int  expDones;
    bit  lvl;
    bit  exp;
    int  firstAct;
    int  firstExp;
    per = fast ? 32 : 64;
    frame = (src == 1) ? 64 : 128;
    bad = 0; dones = 0; expDones = 0; lvl = 1'b0;
    firstAct = 0; firstExp = 0;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      int ph;
      int idx;
      bit d;
      bit expDone;
      @(negedge clk);
      ph = k % per;
      idx = (k / per) % frame;
      d = expBit(src, idx);
      if (bp) begin
        if (ph == 0 && k > 0) lvl = ~lvl;
        if (ph == per / 2 && !d) lvl = ~lvl;
        exp = lvl;
      end else begin
        exp = d ^ (ph >= per / 2);
      end
      expDone = (ph == per - 1) && (idx == frame - 1);
      if (expDone) expDones++;
      if (cycleDone) dones++;
      if (modLevel != exp || cycleDone != expDone ||
          ((src == 0 || src == 3) && wordAddr != 3'(idx / 16))) begin
        if (bad == 0) begin firstAct = k; firstExp = -1; end
        bad++;
      end
    end
    check(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first mismatch at cycle %0d", firstAct);
    check(dones == expDones, "R8 pass pulse count", dones, expDones);
  endtask

  task automatic testUserManchesterSlow();
    startFresh(0, 1'b0, 1'b0);
    runStream(0, 1'b0, 1'b0, 128 * 64 + 200, "R1 R2 R4 user Manchester slow");
  endtask

  task automatic testUserBiphaseFast();
    startFresh(0, 1'b1, 1'b1);
    runStream(0, 1'b1, 1'b1, 128 * 32 + 100, "R1 R2 R5 user bi-phase fast");
  endtask

  task automatic testRomBoth();
    startFresh(1, 1'b0, 1'b0);
    runStream(1, 1'b0, 1'b0, 64 * 64 + 100, "R3 R4 code Manchester slow");
    startFresh(1, 1'b1, 1'b1);
    runStream(1, 1'b1, 1'b1, 64 * 32 * 2 + 50, "R3 R5 code bi-phase fast");
  endtask

  task automatic testCfgFrame();
    startFresh(2, 1'b0, 1'b1);
    runStream(2, 1'b0, 1'b1, 128 * 32 + 50, "R6 configuration frame");
  endtask

  task automatic testAckBurst();
    int bad;
    int doneSeen;
    bad = 0; doneSeen = 0;
    startFresh(0, 1'b0, 1'b1);
    runStream(0, 1'b0, 1'b1, 3 * 32 + 5, "R2 R4 before burst");
    ackReq = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 64; k++) begin
      bit exp;
      @(negedge clk);
      ackReq = (k == 20) ? 1'b1 : 1'b0;  // R9: request inside burst is ignored
      exp = ((k / 8) % 2) == 1;
      if (modLevel != exp) bad++;
      if (cycleDone) doneSeen++;
    end
    ackReq = 1'b0;
    check(bad == 0, "R9 burst square wave", bad, 0);
    check(doneSeen == 0, "R9 no pass pulse in burst", doneSeen, 0);
    runStream(0, 1'b0, 1'b1, 4 * 32, "R9 restart at bit 0 after burst");
  endtask

  task automatic testSourceChange();
    startFresh(2, 1'b1, 1'b1);
    runStream(2, 1'b1, 1'b1, 5 * 32 + 7, "R6 R5 before change");
    srcSel = 2'd1;
    runStream(1, 1'b1, 1'b1, 64 * 32 + 40, "R10 switch to code source");
    srcSel = 2'd3;
    runStream(3, 1'b1, 1'b1, 3 * 32 + 3, "R10 R2 switch to source 3");
  endtask

  initial begin
    for (int w = 0; w < 8; w++) mem[w] = 16'hA5C3 ^ 16'(w * 16'h1357);
    testUserManchesterSlow();
    testUserBiphaseFast();
    testRomBoth();
    testCfgFrame();
    testAckBurst();
    testSourceChange();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule